// File: doc/BRIEF.md
# Serial Converter Reader

This block is the host side of a three-wire link to a sampling serial converter. It drives an active-low chip select and a serial clock, and it reads the converter's data line. One pulse on `start_i` runs one command, chosen by `cmd_i`. The block holds chip select low, toggles the serial clock at a rate set by a system-clock divider, and shifts in the result bits that follow four leading zeros, most significant bit first. It then returns the sample with a one-cycle valid strobe.

The command sets where chip select rises inside the edge count. A full frame has 16 falling edges. A short frame has 12 falling edges and exists only for 8-bit builds. A power-down request raises chip select after the 5th falling edge. A wake-up frame is a dummy full frame whose data is thrown away; the block then stays busy until the power-up settle time has passed since that frame's chip-select fall. After every frame the block keeps chip select high for a minimum quiet time before it can start the next frame.

A start that arrives while the block is busy is held in a one-deep slot and runs once the current command has completed.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are high and `busy_o`, `done_o` and `valid_o` are low.
- R2: While chip select is low, every high phase and every low phase of `sclk_o` lasts exactly `SCLK_HALF` system cycles. The first phase after chip select falls is a high phase. Chip select changes only while `sclk_o` is high.
- R3: Command 2'b00 (full frame) gives 16 falling edges of `sclk_o` and then raises chip select. With `done_o` it pulses `valid_o`, and `sample_o` holds the bits driven after falling edges 4 through 3+`RES`, the first of them in the MSB. Each bit is sampled at the end of the high phase that follows it.
- R4: Command 2'b01 (short frame) gives 12 falling edges and returns a valid sample when `RES` is 8. When `RES` is not 8 the command has no effect beyond a full frame: 16 edges and a valid sample.
- R5: Command 2'b10 (power-down) raises chip select after exactly 5 falling edges, which lies inside the window after the 2nd and before the 10th. It pulses `done_o` without `valid_o`.
- R6: Command 2'b11 (wake-up) runs 16 falling edges and never pulses `valid_o`. Its `done_o`, and the next chip-select fall, come no earlier than `WAKE_CYC` cycles after the wake frame's chip-select fall.
- R7: Between two frames, chip select stays high for at least `QUIET_CYC` system cycles.
- R8: A `start_i` seen while busy is stored together with its command and runs after the current command completes. A further start while one is already stored is dropped.
- R9: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` and `valid_o` are single-cycle pulses, and `valid_o` occurs only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the command on `cmd_i` |
| cmd_i | input | 2 | 00 full, 01 short, 10 power-down, 11 wake-up |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle high |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse when a command and its quiet time have completed |
| valid_o | output | 1 | One-cycle pulse when `sample_o` holds a new result |
| sample_o | output | RES | Last captured result |

## Verification
The hardest situation to reach from the ports is a start that lands while another frame is still shifting, followed by a third start that must be dropped. The bench issues three starts about ten cycles apart inside one full frame. It then counts chip-select frames, done pulses and valid pulses over a long window, and checks the edge count of the queued short frame. Wake-up timing is reached by chaining power-down, wake-up and a full frame back to back, and measuring the gap between chip-select falls at the converter model. A 10-bit instance checks that the short command falls back to a full frame.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int RES       = 10,
  parameter int SCLK_HALF = 3,
  parameter int QUIET_CYC = 5,
  parameter int WAKE_CYC  = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     cmd_i,
  input  logic           sdo_i,
  output logic           cs_n_o,
  output logic           sclk_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           valid_o,
  output logic [RES-1:0] sample_o
);

  localparam int TW = $clog2(SCLK_HALF + 1);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  localparam logic [1:0] C_FULL  = 2'd0;
  localparam logic [1:0] C_SHORT = 2'd1;
  localparam logic [1:0] C_PDN   = 2'd2;
  localparam logic [1:0] C_WAKE  = 2'd3;

  localparam logic [4:0] FE_FIRST = 5'd4;
  localparam logic [4:0] FE_LAST  = 5'(3 + RES);
  localparam logic [4:0] FE_FULL  = 5'd16;
  localparam logic [4:0] FE_SHORT = (RES == 8) ? 5'd12 : 5'd16;
  localparam logic [4:0] FE_PDN   = 5'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO, ST_QUIET} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [4:0]     fe;
  logic [4:0]     fe_end;
  logic [QW-1:0]  qc;
  logic [WW-1:0]  wk;
  logic [1:0]     cmd_q;
  logic [1:0]     pend_cmd;
  logic           pend;
  logic [RES-1:0] shreg;
  logic           phase_end;
  logic           quiet_ok;

  assign busy_o    = (st != ST_IDLE);
  assign phase_end = (tmr == TW'(SCLK_HALF - 1));
  assign fe_end    = (cmd_q == C_PDN)   ? FE_PDN :
                     (cmd_q == C_SHORT) ? FE_SHORT : FE_FULL;
  assign quiet_ok  = (qc >= QW'(QUIET_CYC - 1)) &&
                     ((cmd_q != C_WAKE) || (wk == WW'(WAKE_CYC)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cs_n_o   <= 1'b1;
      sclk_o   <= 1'b1;
      tmr      <= '0;
      fe       <= '0;
      qc       <= '0;
      wk       <= '0;
      cmd_q    <= C_FULL;
      pend     <= 1'b0;
      pend_cmd <= C_FULL;
      shreg    <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      if (wk != WW'(WAKE_CYC)) wk <= wk + 1'b1;
      if (start_i && st != ST_IDLE && !pend) begin
        pend     <= 1'b1;
        pend_cmd <= cmd_i;
      end
      case (st)
        ST_IDLE: begin
          if (start_i || pend) begin
            cmd_q  <= pend ? pend_cmd : cmd_i;
            pend   <= 1'b0;
            cs_n_o <= 1'b0;
            tmr    <= '0;
            fe     <= '0;
            wk     <= '0;
            st     <= ST_HI;
          end
        end
        ST_HI: begin
          if (phase_end) begin
            tmr <= '0;
            if (fe >= FE_FIRST && fe <= FE_LAST) shreg <= {shreg[RES-2:0], sdo_i};
            sclk_o <= 1'b0;
            fe     <= fe + 1'b1;
            st     <= ST_LO;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LO: begin
          if (phase_end) begin
            tmr    <= '0;
            sclk_o <= 1'b1;
            if (fe == fe_end) begin
              cs_n_o <= 1'b1;
              qc     <= '0;
              st     <= ST_QUIET;
            end else begin
              st <= ST_HI;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_QUIET: begin
          if (qc != QW'(QUIET_CYC)) qc <= qc + 1'b1;
          if (quiet_ok) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
            if (cmd_q == C_FULL || cmd_q == C_SHORT) begin
              valid_o  <= 1'b1;
              sample_o <= shreg;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic          cs_d, sclk_d;
  logic [4:0]    nfall;
  logic [QW-1:0] hi_run;
  logic [WW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d       <= 1'b1;
      sclk_d     <= 1'b1;
      nfall      <= '0;
      hi_run     <= QW'(QUIET_CYC);
      since_fall <= WW'(WAKE_CYC);
    end else begin
      cs_d   <= cs_n_o;
      sclk_d <= sclk_o;
      if (cs_d && !cs_n_o) nfall <= '0;
      else if (sclk_d && !sclk_o) nfall <= nfall + 1'b1;
      if (!cs_n_o) hi_run <= '0;
      else if (hi_run != QW'(QUIET_CYC)) hi_run <= hi_run + 1'b1;
      if (cs_d && !cs_n_o) since_fall <= '0;
      else if (since_fall != WW'(WAKE_CYC)) since_fall <= since_fall + 1'b1;
    end
  end

  a_r2_cs_moves_with_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) || $rose(cs_n_o)) |-> sclk_o);

  a_r3_full_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && cmd_q == C_FULL) |-> (nfall == 5'd16));

  a_r4_short_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && cmd_q == C_SHORT) |-> (nfall == ((RES == 8) ? 5'd12 : 5'd16)));

  a_r5_pdn_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && cmd_q == C_PDN) |-> (nfall > 5'd2 && nfall < 5'd10));

  a_r6_wake_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cmd_q == C_FULL || cmd_q == C_SHORT));

  a_r6_wake_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cmd_q == C_WAKE) |-> (since_fall >= WW'(WAKE_CYC)));

  a_r7_quiet_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_run >= QW'(QUIET_CYC)));

  a_r9_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> done_o);

  a_r9_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

endmodule

// File: tb/adc_serial_reader_tb_top.sv
module adc_front_model #(
  parameter int RES = 10
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [11:0] value,
  output logic        sdo,
  output int          frames,
  output int          last_falls,
  output int          last_high,
  output int          last_gap,
  output int          min_run,
  output int          max_run
);
  int cyc = 0;
  int idx = 16;
  int falls = 0;
  int high_run = 1000;
  int run = 0;
  int fall_cyc = -100000;
  logic csd = 1'b1;
  logic sd = 1'b1;
  logic [15:0] word = '0;

  initial begin
    sdo = 1'b0; frames = 0; last_falls = 0; last_high = 0; last_gap = 0;
    min_run = 1000; max_run = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (csd && !cs_n) begin
      idx = 0; falls = 0; run = 1;
      word = 16'(value[RES-1:0]) << (12 - RES);
      last_high = high_run;
      last_gap = cyc - fall_cyc;
      fall_cyc = cyc;
    end else if (!csd) begin
      if (cs_n || sclk != sd) begin
        if (run < min_run) min_run = run;
        if (run > max_run) max_run = run;
        run = 1;
      end else run++;
      if (!cs_n && sd && !sclk) begin idx++; falls++; end
      if (cs_n) begin frames++; last_falls = falls; end
    end
    high_run = cs_n ? high_run + 1 : 0;
    csd = cs_n;
    sd = sclk;
    sdo = (!cs_n && idx < 16) ? word[15-idx] : 1'b0;
  end
endmodule

module adc_serial_reader_tb_top;
  localparam int HALF = 3;
  localparam int QUIET = 5;
  localparam int WAKE = 100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic start8, startw;
  logic [1:0] cmd8, cmdw;
  logic [11:0] val8, valw;
  logic sdo8, sdow;
  logic cs8, sclk8, busy8, done8, valid8;
  logic csw, sclkw, busyw, donew, validw;
  logic [7:0] samp8;
  logic [9:0] sampw;
  int m8_frames, m8_falls, m8_high, m8_gap, m8_min, m8_max;
  int mw_frames, mw_falls, mw_high, mw_gap, mw_min, mw_max;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  adc_serial_reader #(.RES(8), .SCLK_HALF(HALF), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start8), .cmd_i(cmd8), .sdo_i(sdo8),
    .cs_n_o(cs8), .sclk_o(sclk8), .busy_o(busy8), .done_o(done8), .valid_o(valid8),
    .sample_o(samp8));

  adc_serial_reader #(.RES(10), .SCLK_HALF(HALF), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .start_i(startw), .cmd_i(cmdw), .sdo_i(sdow),
    .cs_n_o(csw), .sclk_o(sclkw), .busy_o(busyw), .done_o(donew), .valid_o(validw),
    .sample_o(sampw));

  adc_front_model #(.RES(8)) m8_i (
    .clk(clk), .cs_n(cs8), .sclk(sclk8), .value(val8), .sdo(sdo8), .frames(m8_frames),
    .last_falls(m8_falls), .last_high(m8_high), .last_gap(m8_gap), .min_run(m8_min),
    .max_run(m8_max));

  adc_front_model #(.RES(10)) mw_i (
    .clk(clk), .cs_n(csw), .sclk(sclkw), .value(valw), .sdo(sdow), .frames(mw_frames),
    .last_falls(mw_falls), .last_high(mw_high), .last_gap(mw_gap), .min_run(mw_min),
    .max_run(mw_max));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  function automatic int exp_falls(input bit w, input logic [1:0] c);
    if (c == 2'd2) return 5;
    if (c == 2'd1 && !w) return 12;
    return 16;
  endfunction

  function automatic string tag(input logic [1:0] c);
    case (c)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_cmd(input bit w, input logic [1:0] c, input logic [11:0] v);
    bit seen = 0;
    bit gotv = 0;
    int gots = 0;
    int expv;
    string rq;
    rq = tag(c);
    expv = w ? int'(v[9:0]) : int'(v[7:0]);
    if (w) begin valw = v; cmdw = c; startw = 1'b1; end
    else   begin val8 = v; cmd8 = c; start8 = 1'b1; end
    @(negedge clk);
    start8 = 1'b0; startw = 1'b0;
    chk((w ? busyw : busy8) == 1'b1, "R9", "busy after start", int'(w ? busyw : busy8), 1);
    for (int n = 0; n < 3000 && !seen; n++) begin
      @(negedge clk);
      if (w ? donew : done8) begin
        seen = 1;
        gotv = w ? validw : valid8;
        gots = w ? int'(sampw) : int'(samp8);
      end
    end
    chk(seen, "R9", "done pulse seen", int'(seen), 1);
    chk(gotv == (c < 2'd2), rq, "valid strobe", int'(gotv), int'(c < 2'd2));
    if (c < 2'd2) chk(gots == expv, rq, "sample value", gots, expv);
    chk((w ? mw_falls : m8_falls) == exp_falls(w, c), rq, "falling edges",
        w ? mw_falls : m8_falls, exp_falls(w, c));
    chk((w ? mw_high : m8_high) >= QUIET, "R7", "chip select high before frame",
        w ? mw_high : m8_high, QUIET);
    @(negedge clk);
    chk(!(w ? donew : done8) && !(w ? busyw : busy8), "R9", "done single cycle then idle",
        int'(w ? donew : done8), 0);
  endtask

  task automatic wake_seq(input logic [11:0] v);
    run_cmd(0, 2'd2, v);
    run_cmd(0, 2'd3, v);
    run_cmd(0, 2'd0, v);
    chk(m8_gap >= WAKE, "R6", "cycles from wake fall to next fall", m8_gap, WAKE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog expired: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int f0, nd, nv;
    rst_n = 1'b0; start8 = 1'b0; startw = 1'b0; cmd8 = '0; cmdw = '0; val8 = '0; valw = '0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs8 && sclk8 && csw && sclkw, "R1", "select and clock idle high", int'(cs8 && sclk8), 1);
    chk(!busy8 && !done8 && !valid8 && !busyw && !donew && !validw, "R1", "status low",
        int'(busy8 | done8 | valid8), 0);

    run_cmd(0, 2'd0, 12'h0A5);
    run_cmd(0, 2'd0, 12'h000);
    run_cmd(0, 2'd0, 12'h0FF);
    run_cmd(0, 2'd1, 12'h03C);
    run_cmd(0, 2'd1, 12'h081);
    wake_seq(12'h05A);

    f0 = m8_frames;
    val8 = 12'h06B; cmd8 = 2'd0; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    repeat (10) @(negedge clk);
    cmd8 = 2'd1; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    repeat (10) @(negedge clk);
    cmd8 = 2'd2; start8 = 1'b1;
    @(negedge clk); start8 = 1'b0;
    nd = 0; nv = 0;
    repeat (700) begin
      @(negedge clk);
      if (done8) nd++;
      if (valid8) begin
        nv++;
        chk(samp8 == 8'h6B, "R8", "queued sample", int'(samp8), 'h6B);
      end
    end
    chk(m8_frames - f0 == 2, "R8", "frames after three starts", m8_frames - f0, 2);
    chk(nd == 2, "R8", "done pulses", nd, 2);
    chk(nv == 2, "R8", "valid pulses", nv, 2);
    chk(m8_falls == 12, "R8", "queued command kept its code", m8_falls, 12);

    run_cmd(1, 2'd0, 12'h3FF);
    run_cmd(1, 2'd0, 12'h201);
    run_cmd(1, 2'd1, 12'h155);
    run_cmd(1, 2'd2, 12'h0F0);
    run_cmd(1, 2'd3, 12'h0F0);

    for (int i = 0; i < 40; i++) begin
      int sel;
      logic [11:0] v;
      sel = int'($urandom % 8);
      v = 12'($urandom);
      if (sel < 4)       run_cmd(0, 2'd0, v);
      else if (sel < 6)  run_cmd(0, 2'd1, v);
      else if (sel == 6) wake_seq(v);
      else               run_cmd(1, 2'($urandom % 2), v);
    end

    chk(m8_min == HALF && m8_max == HALF, "R2", "8-bit clock phase length", m8_min, HALF);
    chk(m8_max == HALF, "R2", "8-bit longest phase", m8_max, HALF);
    chk(mw_min == HALF && mw_max == HALF, "R2", "10-bit clock phase length", mw_min, HALF);
    summary();
    $finish;
  end
endmodule